// File: doc/BRIEF.md
# Iterative SHA-1 Compression Engine

This block applies the SHA-1 compression function to one fully padded 512-bit message block at a time and keeps the resulting 160-bit chaining value on its `digest` output. It evaluates one of the 80 rounds per clock. A short initialization cycle comes first and a final feed-forward addition comes last, so every block costs a fixed 82 cycles. The host handles padding and length encoding.

A block is offered with one of two start strobes. `init` begins a new message from the standard initial hash value 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0 (hex). `next` continues a message from the digest currently held. `ready` is the back-pressure signal. A strobe is accepted only in a cycle where `ready` is high, and the 512-bit `block` is sampled in that same cycle. A strobe seen while `ready` is low is dropped rather than queued, so the host must hold or repeat it until `ready` returns. After the accepting cycle, `block` may change freely. `digest_valid` falls when a block is accepted. It rises together with `ready` when the new digest is in place.

Top module: `sha1_iter_core`

## Requirements
- R1: After reset, `ready` is 1, `digest_valid` is 0 and `digest` is all zeros.
- R2: A block accepted with `init` produces the SHA-1 compression of that block from the standard initial hash value, including the known single-block vector for the message "abc" (a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d).
- R3: A block accepted with `next` produces the compression of that block chained from the digest held at acceptance, so that two consecutive blocks give the two-block message hash.
- R4: `digest_valid` rises exactly 82 clock cycles after the rising edge that accepted the block.
- R5: `ready` goes low in the cycle after a block is accepted, stays low while the block is processed, and is high whenever `digest_valid` is high.
- R6: While `ready` is low, `init`, `next` and `block` have no effect on the result. After acceptance, changes on `block` are also ignored.
- R7: `digest_valid` clears on acceptance. `digest` keeps its previous value until the cycle in which `digest_valid` rises.
- R8: When `init` and `next` are both high in the accepting cycle, `init` takes priority and the initial hash value is used.
- R9: Message word 0 is `block[511:480]` and word 15 is `block[31:0]`. The first digest word (the H0 sum) is `digest[159:128]` and the last is `digest[31:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Start a new message from the initial hash value |
| next | input | 1 | Continue the message from the current digest |
| block | input | 512 | Padded message block, word 0 in the top bits |
| ready | output | 1 | High when a start strobe will be accepted |
| digest_valid | output | 1 | High when `digest` holds the result of the last block |
| digest | output | 160 | Chaining value / hash result |

## Verification
The bound checker watches the control contract on every cycle. It checks that `ready` drops after acceptance, that `digest_valid` clears on acceptance and implies `ready`, that `digest` moves only when `digest_valid` rises, and, through its own counter, that the 82-cycle latency holds. The hash value itself, the chaining across blocks, the priority of `init`, the word order and the immunity to strobes and block changes during processing can only be shown by the bench. It compares each digest with a model computed in the bench, using the "abc" vector, a two-block chain and seeded random blocks.

// File: rtl/sha1_iter_pkg.sv
package sha1_iter_pkg;
  localparam int WORD_W      = 32;
  localparam int BLOCK_WORDS = 16;
  localparam int STATE_WORDS = 5;
  localparam int ROUNDS      = 80;
  localparam int RND_W       = $clog2(ROUNDS);
  localparam int BLOCK_W     = WORD_W * BLOCK_WORDS;
  localparam int DIGEST_W    = WORD_W * STATE_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  // index STATE_WORDS-1 is word a (top bits), index 0 is word e
  typedef logic [STATE_WORDS-1:0][WORD_W-1:0] wvec_t;
  typedef logic [RND_W-1:0] rnd_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic wvec_t start_value();
    wvec_t v;
    v[4] = 32'h67452301;
    v[3] = 32'hEFCDAB89;
    v[2] = 32'h98BADCFE;
    v[1] = 32'h10325476;
    v[0] = 32'hC3D2E1F0;
    return v;
  endfunction

  function automatic word_t round_const(input rnd_t t);
    if (t < rnd_t'(20))      return 32'h5A827999;
    else if (t < rnd_t'(40)) return 32'h6ED9EBA1;
    else if (t < rnd_t'(60)) return 32'h8F1BBCDC;
    else                     return 32'hCA62C1D6;
  endfunction

  function automatic word_t round_mix(input rnd_t t, input word_t b,
                                      input word_t c, input word_t d);
    if (t < rnd_t'(20))                        return (b & c) | (~b & d);
    else if (t >= rnd_t'(40) && t < rnd_t'(60)) return (b & c) | (b & d) | (c & d);
    else                                       return b ^ c ^ d;
  endfunction
endpackage

// File: rtl/sha1_iter_wsched.sv
module sha1_iter_wsched
  import sha1_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [BLOCK_W-1:0] block,
  output word_t              w_cur
);
  // win[i] holds W[t+i] while round t executes
  word_t win [BLOCK_WORDS];
  word_t w_new;

  assign w_new = rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
  assign w_cur = win[0];

  for (genvar i = 0; i < BLOCK_WORDS; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win[i] <= '0;
      end else if (load) begin
        win[i] <= block[BLOCK_W-1-i*WORD_W -: WORD_W];
      end else if (shift) begin
        if (i == BLOCK_WORDS-1) win[i] <= w_new;
        else                    win[i] <= win[(i+1) % BLOCK_WORDS];
      end
    end
  end
endmodule

// File: rtl/sha1_iter_round.sv
module sha1_iter_round
  import sha1_iter_pkg::*;
(
  input  wvec_t vin,
  input  word_t w,
  input  rnd_t  t,
  output wvec_t vout
);
  word_t tmp;

  assign tmp = rotl(vin[4], 5) + round_mix(t, vin[3], vin[2], vin[1])
             + vin[0] + round_const(t) + w;

  always_comb begin
    vout[4] = tmp;
    vout[3] = vin[4];
    vout[2] = rotl(vin[3], 30);
    vout[1] = vin[2];
    vout[0] = vin[1];
  end
endmodule

// File: rtl/sha1_iter_ctrl.sv
module sha1_iter_ctrl
  import sha1_iter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic next,
  output logic ready,
  output logic accept,
  output logic use_iv,
  output logic seed,
  output logic step,
  output logic finish,
  output rnd_t rnd
);
  typedef enum logic [1:0] {S_IDLE, S_SEED, S_ROUND, S_FINAL} st_t;
  st_t  st_q;
  rnd_t rnd_q;
  logic iv_q;

  assign ready  = (st_q == S_IDLE);
  assign accept = ready && (init || next);
  assign seed   = (st_q == S_SEED);
  assign step   = (st_q == S_ROUND);
  assign finish = (st_q == S_FINAL);
  assign use_iv = iv_q;
  assign rnd    = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      rnd_q <= '0;
      iv_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          st_q <= S_SEED;
          iv_q <= init;
        end
        S_SEED: begin
          st_q  <= S_ROUND;
          rnd_q <= '0;
        end
        S_ROUND: begin
          if (rnd_q == rnd_t'(ROUNDS-1)) st_q <= S_FINAL;
          else                            rnd_q <= rnd_q + rnd_t'(1);
        end
        S_FINAL: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sha1_iter_core.sv
module sha1_iter_core
  import sha1_iter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init,
  input  logic                next,
  input  logic [BLOCK_W-1:0]  block,
  output logic                ready,
  output logic                digest_valid,
  output logic [DIGEST_W-1:0] digest
);
  logic  accept, use_iv, seed, step, finish;
  rnd_t  rnd;
  word_t w_cur;
  wvec_t vars_q, base_q, dig_q, vars_next, start_v;
  logic  valid_q;

  sha1_iter_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init), .next(next),
    .ready(ready), .accept(accept), .use_iv(use_iv), .seed(seed),
    .step(step), .finish(finish), .rnd(rnd)
  );

  sha1_iter_wsched u_wsched (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(step),
    .block(block), .w_cur(w_cur)
  );

  sha1_iter_round u_round (
    .vin(vars_q), .w(w_cur), .t(rnd), .vout(vars_next)
  );

  assign start_v = use_iv ? start_value() : dig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vars_q <= '0;
      base_q <= '0;
    end else if (seed) begin
      vars_q <= start_v;
      base_q <= start_v;
    end else if (step) begin
      vars_q <= vars_next;
    end
  end

  for (genvar i = 0; i < STATE_WORDS; i++) begin : g_ff
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig_q[i] <= '0;
      else if (finish) dig_q[i] <= base_q[i] + vars_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= 1'b0;
    else if (accept) valid_q <= 1'b0;
    else if (finish) valid_q <= 1'b1;
  end

  assign digest       = dig_q;
  assign digest_valid = valid_q;
endmodule

// File: rtl/sha1_iter_core_chk.sv
module sha1_iter_core_chk
  import sha1_iter_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                init,
  input logic                next,
  input logic                ready,
  input logic                digest_valid,
  input logic [DIGEST_W-1:0] digest
);
  localparam int LAT = ROUNDS + 2;
  logic [7:0] lat_q;
  logic       take;

  assign take = ready && (init || next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (take)  lat_q <= '0;
    else if (!ready && lat_q != 8'hFF) lat_q <= lat_q + 8'd1;
  end

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ready);

  a_r7_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !digest_valid);

  a_r5_valid_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid |-> ready);

  a_r7_digest_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digest) |-> $rose(digest_valid));

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_valid) |-> (lat_q == 8'(LAT)));
endmodule

bind sha1_iter_core sha1_iter_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .next(next),
  .ready(ready), .digest_valid(digest_valid), .digest(digest)
);

// File: tb/tb_sha1_iter_core.sv
module tb_sha1_iter_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0;
  logic         next = 1'b0;
  logic [511:0] block = '0;
  logic         ready, digest_valid;
  logic [159:0] digest;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sha1_iter_core dut (
    .clk(clk), .rst_n(rst_n), .init(init), .next(next), .block(block),
    .ready(ready), .digest_valid(digest_valid), .digest(digest)
  );

  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] model(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = m[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] rnd_block();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode: 0 = next, 1 = init, 2 = both strobes; disturb = poke strobes mid-run
  task automatic run(input int mode, input logic [511:0] blk, input bit disturb,
                     input string req);
    logic [159:0] prev, exp;
    int lat;
    @(negedge clk);
    while (!ready) @(negedge clk);
    prev = digest;
    exp  = model((mode == 0) ? prev : IV, blk);
    init = (mode != 0);
    next = (mode != 1);
    block = blk;
    @(negedge clk);
    init = 1'b0; next = 1'b0;
    block = rnd_block();               // R6: ignored after acceptance
    check("R5 ready low", {159'd0, ready}, 160'd0);
    check("R7 valid cleared", {159'd0, digest_valid}, 160'd0);
    lat = 0;
    while (!digest_valid && lat < 200) begin
      if (lat == 40) check("R7 digest held", digest, prev);
      if (disturb && lat == 30) begin init = 1'b1; next = 1'b0; block = rnd_block(); end
      if (disturb && lat == 31) begin init = 1'b0; next = 1'b1; end
      if (disturb && lat == 32) next = 1'b0;
      @(negedge clk);
      lat++;
    end
    check("R4 latency", 160'(lat), 160'd82);
    check("R5 ready on done", {159'd0, ready}, 160'd1);
    check(req, digest, exp);
  endtask

  initial begin
    logic [511:0] abc;
    void'($urandom(32'h5EED_0001));
    repeat (3) @(negedge clk);
    check("R1 ready", {159'd0, ready}, 160'd1);
    check("R1 valid", {159'd0, digest_valid}, 160'd0);
    check("R1 digest", digest, 160'd0);
    rst_n = 1'b1;

    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;
    run(1, abc, 1'b0, "R2 R9 abc vector");
    check("R2 known digest", digest, 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);

    run(1, rnd_block(), 1'b0, "R2 init random");
    run(0, rnd_block(), 1'b0, "R3 next chains");
    run(0, rnd_block(), 1'b1, "R6 strobes during busy");
    run(2, rnd_block(), 1'b0, "R8 init priority");
    for (int i = 0; i < 6; i++)
      run(($urandom % 2 == 0) ? 0 : 1, rnd_block(), (i % 2) == 1, "R3 R2 random mix");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule